// File: doc/BRIEF.md
# Supply-Signalled Calibration Programming Sequencer

This block stores a small calibration number in a non-volatile cell. The only programming channel is the supply rail. Three external comparators turn the rail voltage into three digital flags:

- a high flag, set at about 5.1 V;
- a middle flag, set at about 4.5 V;
- a low flag, set at about 2.5 V.

Every flag passes through a two-flop synchronizer. A flag level is then accepted only after it has held for a number of clocks set by a parameter.

A rise of the rail to the high level opens a read-back mode. A drop to the low level during a motor pulse arms a programming sequence. A drop to the low level between motor pulses cancels the mode. After arming, the sequence runs in this order:

1. The next rise to the high level erases the cell.
2. Short dips to the middle level are counted, one per dip.
3. A drop to the low level closes the count.
4. The next rise to the high level writes the counted value.
5. A final drop to the low level returns the block to normal operation.

The erase and the write each hold their strobe for a parameterised number of clocks, which stands in for the cell's fixed operation time. The cell model counts completed writes. Once the write limit is reached, an armed sequence is refused and the stored value is kept.

Top module: `supply_prog_seq`

## Requirements
- R1: While and after synchronous reset, every output is 0, the stored value is 0 and the sequencer is in normal operation.
- R2: A flag change is acted on only after its synchronized value has differed from the accepted value for STABLE consecutive clocks. The synchronizer adds two clocks. A pulse shorter than STABLE clocks has no effect.
- R3: From normal operation, an accepted rise of the high flag enters read-back mode, shown by `chk_o` = 1.
- R4: In read-back mode, an accepted rise of the low flag arms the sequence if `motor_i` is 1 in that clock. If `motor_i` is 0, the block returns to normal operation and no erase follows.
- R5: In the armed state, an accepted rise of the high flag raises `erase_o` for exactly OP_CYC clocks. `cal_o` becomes 0 in the clock where `erase_o` falls, and `test_o` reads 1 from then until the data input ends.
- R6: During data input, each accepted rise of the high flag while the middle flag is accepted as 1 adds one to `wdata_o`. `wdata_o` is cleared when the erase starts. An accepted rise of the low flag ends data input and clears `test_o`.
- R7: The count saturates at 2^W-1. An increment that is attempted at that value sets `ovf_o` instead. `ovf_o` stays set until the next erase starts.
- R8: After data input, an accepted rise of the high flag raises `store_o` for exactly OP_CYC clocks. `cal_o` takes the value of `wdata_o` in the clock where `store_o` falls.
- R9: After the write, an accepted rise of the low flag returns the block to normal operation. `cal_o` keeps the written value.
- R10: After MAX_PROG completed writes, an accepted rise of the high flag in the armed state returns the block to read-back mode without any erase or write. `cal_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_hi_i | input | 1 | Comparator flag: rail at or above the high level (asynchronous) |
| sup_mid_i | input | 1 | Comparator flag: rail at or above the middle level (asynchronous) |
| sup_lo_i | input | 1 | Comparator flag: rail at or below the low level (asynchronous) |
| motor_i | input | 1 | Motor pulse in progress (synchronous to clk) |
| erase_o | output | 1 | Erase strobe to the cell |
| store_o | output | 1 | Write strobe to the cell |
| wdata_o | output | W | Counted value presented for writing |
| cal_o | output | W | Value held in the cell |
| test_o | output | 1 | Status: cell erased, data input open |
| ovf_o | output | 1 | Status: count saturated |
| chk_o | output | 1 | Read-back mode active |

## Verification
The bench builds the block with a stable window of 3 clocks, an operation time of 6 clocks and a write limit of 3. With these values, a two-clock glitch falls just inside the filter's rejection window. A full erase plus write fits in a few dozen clocks. The refused fourth programming attempt is reached after only three complete sequences. The 6-bit word is kept, so a run of 66 dips drives the counter through saturation and sets the overflow flag.

// File: rtl/supply_prog_pkg.sv
package supply_prog_pkg;
  localparam int LV_HI  = 0;
  localparam int LV_MID = 1;
  localparam int LV_LO  = 2;
  localparam int N_LV   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ARMED,
    ST_ERASE,
    ST_DATA,
    ST_WAIT,
    ST_STORE,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/level_filter.sv
module level_filter #(
  parameter int STABLE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic flt_o
);
  localparam int CW = $clog2(STABLE + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      run_q <= '0;
      flt_o <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q == flt_o) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        run_q <= '0;
        flt_o <= s2_q;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R2: the accepted value only flips after a disagreeing synchronized sample
  p_flip_needs_run_r2: assert property (@(posedge clk) disable iff (rst)
    (flt_o != $past(flt_o)) |-> ($past(s2_q) == flt_o));
endmodule

// File: rtl/cal_store.sv
module cal_store #(
  parameter int W        = 6,
  parameter int OP_CYC   = 164,
  parameter int MAX_PROG = 100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         erase_i,
  input  logic         store_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cal_o,
  output logic         done_o,
  output logic         locked_o
);
  localparam int TW = $clog2(OP_CYC + 1);
  localparam int PW = $clog2(MAX_PROG + 1);
  localparam logic [TW-1:0] T_END = TW'(OP_CYC - 1);
  localparam logic [PW-1:0] P_MAX = PW'(MAX_PROG);

  logic [TW-1:0] tmr_q;
  logic [PW-1:0] prog_q;
  logic          busy;

  assign busy     = erase_i | store_i;
  assign done_o   = busy && (tmr_q == T_END);
  assign locked_o = (prog_q >= P_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q  <= '0;
      prog_q <= '0;
      cal_o  <= '0;
    end else if (done_o) begin
      tmr_q <= '0;
      if (erase_i) begin
        cal_o <= '0;
      end else begin
        cal_o  <= wdata_i;
        prog_q <= prog_q + 1'b1;
      end
    end else if (busy) begin
      tmr_q <= tmr_q + 1'b1;
    end else begin
      tmr_q <= '0;
    end
  end

  // R10: an erase never starts once the write limit is reached
  p_no_erase_locked_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(erase_i) |-> (prog_q < P_MAX));
  // R8: the stored value moves only at the end of a commanded operation
  p_cal_moves_r8: assert property (@(posedge clk) disable iff (rst)
    (cal_o != $past(cal_o)) |-> $past(erase_i || store_i));
  // R5: erase and write are never commanded together
  p_single_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    !(erase_i && store_i));
endmodule

// File: rtl/prog_fsm.sv
module prog_fsm
  import supply_prog_pkg::*;
#(
  parameter int W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_LV-1:0] lvl_i,
  input  logic            motor_i,
  input  logic            done_i,
  input  logic            locked_i,
  output logic            erase_o,
  output logic            store_o,
  output logic            test_o,
  output logic            chk_o,
  output logic [W-1:0]    wdata_o,
  output logic            ovf_o
);
  localparam logic [W-1:0] CNT_TOP = '1;

  seq_state_t state_q, nxt;
  logic hi_d_q, lo_d_q;
  logic hi_rise, lo_rise, mid_on;

  assign hi_rise = lvl_i[LV_HI] & ~hi_d_q;
  assign lo_rise = lvl_i[LV_LO] & ~lo_d_q;
  assign mid_on  = lvl_i[LV_MID];

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_IDLE:  if (hi_rise) nxt = ST_CHECK;
      ST_CHECK: if (lo_rise) nxt = motor_i ? ST_ARMED : ST_IDLE;
      ST_ARMED: if (hi_rise) nxt = locked_i ? ST_CHECK : ST_ERASE;
      ST_ERASE: if (done_i)  nxt = ST_DATA;
      ST_DATA:  if (lo_rise) nxt = ST_WAIT;
      ST_WAIT:  if (hi_rise) nxt = ST_STORE;
      ST_STORE: if (done_i)  nxt = ST_DONE;
      ST_DONE:  if (lo_rise) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      hi_d_q  <= 1'b0;
      lo_d_q  <= 1'b0;
      erase_o <= 1'b0;
      store_o <= 1'b0;
      test_o  <= 1'b0;
      chk_o   <= 1'b0;
      wdata_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      state_q <= nxt;
      hi_d_q  <= lvl_i[LV_HI];
      lo_d_q  <= lvl_i[LV_LO];
      erase_o <= (nxt == ST_ERASE);
      store_o <= (nxt == ST_STORE);
      test_o  <= (nxt == ST_DATA);
      chk_o   <= (nxt == ST_CHECK);
      if (state_q == ST_ARMED && nxt == ST_ERASE) begin
        wdata_o <= '0;
        ovf_o   <= 1'b0;
      end else if (state_q == ST_DATA && hi_rise && mid_on) begin
        if (wdata_o == CNT_TOP) ovf_o <= 1'b1;
        else                    wdata_o <= wdata_o + 1'b1;
      end
    end
  end

  // R7: overflow is only flagged with the counter pinned at its top
  p_ovf_at_top_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (wdata_o == CNT_TOP));
  // R6: the count moves by one step up or is cleared
  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    (wdata_o != $past(wdata_o)) |-> (wdata_o == $past(wdata_o) + W'(1) || wdata_o == '0));
  // R5: the erased indication only follows an erase
  p_test_after_erase_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(test_o) |-> $past(erase_o));
  // R4: arming only happens with a motor pulse present
  p_arm_needs_motor_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARMED && $past(state_q) == ST_CHECK) |-> $past(motor_i));
endmodule

// File: rtl/supply_prog_seq.sv
module supply_prog_seq
  import supply_prog_pkg::*;
#(
  parameter int W        = 6,
  parameter int STABLE   = 3,
  parameter int OP_CYC   = 164,
  parameter int MAX_PROG = 100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sup_hi_i,
  input  logic         sup_mid_i,
  input  logic         sup_lo_i,
  input  logic         motor_i,
  output logic         erase_o,
  output logic         store_o,
  output logic [W-1:0] wdata_o,
  output logic [W-1:0] cal_o,
  output logic         test_o,
  output logic         ovf_o,
  output logic         chk_o
);
  logic [N_LV-1:0] lvl_raw, lvl_flt;
  logic done, locked;

  assign lvl_raw[LV_HI]  = sup_hi_i;
  assign lvl_raw[LV_MID] = sup_mid_i;
  assign lvl_raw[LV_LO]  = sup_lo_i;

  for (genvar g = 0; g < N_LV; g++) begin : g_flt
    level_filter #(.STABLE(STABLE)) u_flt (
      .clk   (clk),
      .rst   (rst),
      .raw_i (lvl_raw[g]),
      .flt_o (lvl_flt[g])
    );
  end

  prog_fsm #(.W(W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .lvl_i    (lvl_flt),
    .motor_i  (motor_i),
    .done_i   (done),
    .locked_i (locked),
    .erase_o  (erase_o),
    .store_o  (store_o),
    .test_o   (test_o),
    .chk_o    (chk_o),
    .wdata_o  (wdata_o),
    .ovf_o    (ovf_o)
  );

  cal_store #(.W(W), .OP_CYC(OP_CYC), .MAX_PROG(MAX_PROG)) u_cell (
    .clk      (clk),
    .rst      (rst),
    .erase_i  (erase_o),
    .store_i  (store_o),
    .wdata_i  (wdata_o),
    .cal_o    (cal_o),
    .done_o   (done),
    .locked_o (locked)
  );
endmodule

// File: tb/supply_prog_seq_test.sv
module supply_prog_seq_test;
  localparam int W = 6, STABLE = 3, OP_CYC = 6, MAX_PROG = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic hi = 1'b0, mid = 1'b0, lo = 1'b0, motor = 1'b0;
  logic erase_o, store_o, test_o, ovf_o, chk_o;
  logic [W-1:0] wdata_o, cal_o;

  int vectors = 0, miscompares = 0;
  bit finished = 0, erase_seen = 0;

  always #4 clk = ~clk;

  supply_prog_seq #(.W(W), .STABLE(STABLE), .OP_CYC(OP_CYC), .MAX_PROG(MAX_PROG)) uut (
    .clk(clk), .rst(rst), .sup_hi_i(hi), .sup_mid_i(mid), .sup_lo_i(lo),
    .motor_i(motor), .erase_o(erase_o), .store_o(store_o), .wdata_o(wdata_o),
    .cal_o(cal_o), .test_o(test_o), .ovf_o(ovf_o), .chk_o(chk_o));

  // reference model: mode 0 idle,1 check,2 armed,3 erase,4 data,5 wait,6 store,7 done
  int m_mode, m_cnt, m_cal, m_progs, m_tmr;
  bit m_ovf;
  bit [2:0] m_acc, m_acc_d;
  bit [2:0] hist [0:STABLE+1];

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_cal = 0; m_progs = 0; m_tmr = 0; m_ovf = 0;
      m_acc = 0; m_acc_d = 0;
      foreach (hist[i]) hist[i] = 0;
    end else begin
      bit hr, lr, busy, fin, lock;
      bit [2:0] nacc;
      int nm;
      hr = m_acc[0] && !m_acc_d[0];
      lr = m_acc[2] && !m_acc_d[2];
      lock = (m_progs >= MAX_PROG);
      busy = (m_mode == 3 || m_mode == 6);
      fin = busy && (m_tmr == OP_CYC - 1);
      nm = m_mode;
      case (m_mode)
        0: if (hr) nm = 1;
        1: if (lr) nm = motor ? 2 : 0;
        2: if (hr) nm = lock ? 1 : 3;
        3: if (fin) nm = 4;
        4: if (lr) nm = 5;
        5: if (hr) nm = 6;
        6: if (fin) nm = 7;
        default: if (lr) nm = 0;
      endcase
      if (fin) begin
        if (m_mode == 3) m_cal = 0;
        else begin m_cal = m_cnt; m_progs++; end
        m_tmr = 0;
      end else if (busy) m_tmr++;
      else m_tmr = 0;
      if (m_mode == 2 && nm == 3) begin m_cnt = 0; m_ovf = 0; end
      else if (m_mode == 4 && hr && m_acc[1]) begin
        if (m_cnt == (1 << W) - 1) m_ovf = 1; else m_cnt++;
      end
      m_mode = nm;
      for (int i = STABLE + 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = {lo, mid, hi};
      nacc = m_acc;
      for (int b = 0; b < 3; b++) begin
        bit all;
        all = 1;
        for (int k = 2; k <= STABLE + 1; k++) if (hist[k][b] == m_acc[b]) all = 0;
        if (all) nacc[b] = !m_acc[b];
      end
      m_acc_d = m_acc;
      m_acc = nacc;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (erase_o) erase_seen = 1;
      check("R5", "erase_o", int'(erase_o), int'(m_mode == 3));
      check("R8", "store_o", int'(store_o), int'(m_mode == 6));
      check("R6", "test_o",  int'(test_o),  int'(m_mode == 4));
      check("R3", "chk_o",   int'(chk_o),   int'(m_mode == 1));
      check("R6", "wdata_o", int'(wdata_o), m_cnt);
      check("R8", "cal_o",   int'(cal_o),   m_cal);
      check("R7", "ovf_o",   int'(ovf_o),   int'(m_ovf));
    end
  end

  // level 0 normal, 1 low, 2 middle, 3 high
  task automatic set_lvl(int lv, int hold);
    @(negedge clk);
    hi  = (lv == 3);
    mid = (lv >= 2);
    lo  = (lv == 1);
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic program_seq(int dips);
    set_lvl(3, 12);
    motor = 1'b1;
    set_lvl(1, 12);
    motor = 1'b0;
    set_lvl(3, 20);
    check("R5", "test_o after erase", int'(test_o), 1);
    check("R5", "cal_o after erase", int'(cal_o), 0);
    for (int d = 0; d < dips; d++) begin
      set_lvl(2, 10);
      set_lvl(3, 10);
    end
    set_lvl(1, 12);
    check("R6", "test_o after data end", int'(test_o), 0);
    set_lvl(3, 20);
    set_lvl(1, 12);
    check("R9", "chk_o after final drop", int'(chk_o), 0);
    set_lvl(0, 12);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1", "outputs in reset", int'({erase_o, store_o, test_o, ovf_o, chk_o}), 0);
    check("R1", "cal_o in reset", int'(cal_o), 0);
    rst = 1'b0;
    set_lvl(0, 6);
    check("R1", "chk_o after reset", int'(chk_o), 0);
    // R2: a two-clock spike is rejected
    set_lvl(3, 2);
    set_lvl(0, 12);
    check("R2", "chk_o after glitch", int'(chk_o), 0);
    set_lvl(3, 12);
    check("R3", "chk_o at high", int'(chk_o), 1);
    // R4: low without motor pulse cancels
    set_lvl(1, 12);
    check("R4", "chk_o after unarmed drop", int'(chk_o), 0);
    set_lvl(0, 8);
    set_lvl(3, 20);
    check("R4", "no erase without motor", int'(erase_seen), 0);
    set_lvl(1, 12);
    set_lvl(0, 12);
    program_seq(5);
    check("R8", "cal_o after store of 5", int'(cal_o), 5);
    check("R6", "wdata_o count of 5", int'(wdata_o), 5);
    set_lvl(3, 12);
    check("R9", "read-back keeps 5", int'(cal_o), 5);
    set_lvl(1, 12);
    set_lvl(0, 12);
    program_seq(66);
    check("R7", "saturated count", int'(wdata_o), 63);
    check("R7", "overflow flag", int'(ovf_o), 1);
    check("R8", "cal_o after saturated store", int'(cal_o), 63);
    program_seq(2);
    check("R7", "overflow cleared by erase", int'(ovf_o), 0);
    check("R8", "cal_o after store of 2", int'(cal_o), 2);
    // R10: fourth attempt refused
    erase_seen = 0;
    set_lvl(3, 12);
    motor = 1'b1;
    set_lvl(1, 12);
    motor = 1'b0;
    set_lvl(3, 24);
    check("R10", "back in read-back", int'(chk_o), 1);
    check("R10", "no erase when locked", int'(erase_seen), 0);
    check("R10", "cal_o kept", int'(cal_o), 2);
    set_lvl(1, 12);
    set_lvl(0, 8);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog R1-wide actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule